// File: doc/BRIEF.md
# Address-Mapped Marker Position Latch

This block is a slave on a peripheral I/O bus of a display board. It compares the upper bits of a 20-bit I/O address with three fixed 512-location windows. The first window selects the board's control registers. The other two windows hold the horizontal positions of two screen markers.

When an access falls in any window, the block raises a request to an external arbiter. It holds the request until the arbiter grants it and the bus cycle ends. The data-buffer enable comes on only after a grant. A one-cycle read or write strobe marks the start of the granted transfer.

A granted write into a marker window sets that marker's 9-bit position. The position is taken from the low nine bits of the write address, so the value written on the data bus has no part in it.

Top module: `marker_addr_latch`

## Requirements
- R1: `ctl_sel` is high in exactly the cycles where `bus_rd` or `bus_wr` is high and the address lies in 0x0FA00..0x0FBFF, which is address bits [19:9] equal to 0x07D.
- R2: `mk_stb[0]` is high for an active read or write in 0x0FC00..0x0FDFF (bits [19:9] = 0x07E). `mk_stb[1]` is high for an active read or write in 0x0FE00..0x0FFFF (bits [19:9] = 0x07F). Both are combinational from the bus.
- R3: An access outside the three windows raises no select, no strobe and no request, and it leaves both marker positions unchanged.
- R4: `arb_req` rises one cycle after a clock edge that samples an in-window access. It stays high while the bus cycle continues, and it falls one cycle after a sampled edge where `bus_rd` and `bus_wr` are both low.
- R5: `buf_en` rises only in the cycle after an edge that sampled `arb_gnt` high while `arb_req` was high. It stays low however long the grant is delayed, and it falls together with `arb_req`.
- R6: At the start of each granted transfer, `wr_en` (for a write) or `rd_en` (for a read) is high for exactly one cycle, in the first cycle of `buf_en`.
- R7: A granted write in marker window k sets `mk_pos[k]` to the low nine address bits. The new value is visible in the cycle after the granting edge. For example, 0x0FCE3 gives marker 0 the value 0x0E3, and 0x0FFF9 gives marker 1 the value 0x1F9.
- R8: Marker positions stay unchanged after any of these: a read in a marker window, a write in the control window, and an access whose bus cycle ends before a grant arrives.
- R9: Synchronous active-high `rst` clears both marker positions to 0. It also drives `arb_req`, `buf_en`, `rd_en` and `wr_en` low.
- R10: A grant that arrives while no request is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | I/O address, held stable for the whole bus cycle |
| bus_rd | input | 1 | Read cycle active |
| bus_wr | input | 1 | Write cycle active |
| arb_gnt | input | 1 | Grant from the board arbiter |
| arb_req | output | 1 | Board access request to the arbiter |
| buf_en | output | 1 | Data buffer enable, high only after a grant |
| rd_en | output | 1 | One-cycle read strobe at the start of a granted read |
| wr_en | output | 1 | One-cycle write strobe at the start of a granted write |
| ctl_sel | output | 1 | Control-register window select |
| mk_stb | output | 2 | Marker window strobes; bit k is marker k |
| mk_pos | output | 2x9 | Latched horizontal positions; `mk_pos[k]` is marker k |

## Verification
On every cycle the assertions check the following:
- At most one window select is high at a time.
- A request is never raised without an in-window access.
- The request is held while the bus cycle continues.
- The buffer enable rises only after a grant.
- The read and write strobes are single-cycle pulses that fall inside the buffer enable.
- A marker moves only with a write strobe.
- Reset clears the outputs.

The bench's scenarios are needed to show the actual positions taken from the address, the exact window edges (0x0F9FF, 0x0FC00, 0x0FDFF, 0x0FE00), reads and control writes that leave the markers alone, a delayed grant, an aborted request, and a stray grant.

// File: rtl/mal_pkg.sv
package mal_pkg;
    localparam int ADDR_W_DEF = 20;
    localparam int POS_W_DEF  = 9;
    localparam int NUM_MK     = 2;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_ACT  = 2'd2
    } hs_state_e;
endpackage

// File: rtl/mal_decode.sv
module mal_decode #(
    parameter int PAGE_W = 11,
    parameter logic [PAGE_W-1:0] CTL_PAGE = 11'h07D,
    parameter logic [PAGE_W-1:0] MK_PAGE0 = 11'h07E
) (
    input  logic                        cyc,
    input  logic [PAGE_W-1:0]           page,
    output logic                        ctl_hit,
    output logic [mal_pkg::NUM_MK-1:0]  mk_hit,
    output logic                        any_hit
);
    import mal_pkg::*;

    assign ctl_hit = cyc && (page == CTL_PAGE);

    for (genvar k = 0; k < NUM_MK; k++) begin : g_win
        localparam logic [PAGE_W-1:0] WIN_PAGE = MK_PAGE0 + PAGE_W'(k);
        assign mk_hit[k] = cyc && (page == WIN_PAGE);
    end

    assign any_hit = ctl_hit || (|mk_hit);
endmodule

// File: rtl/mal_handshake.sv
module mal_handshake #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_rd,
    input  logic              cyc_wr,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic              arb_gnt,
    output logic              arb_req,
    output logic              buf_en,
    output logic              rd_en,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr_q,
    output logic              commit
);
    import mal_pkg::*;

    typedef struct packed {
        hs_state_e         st;
        logic              req;
        logic              buf_on;
        logic              rd_p;
        logic              wr_p;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
    } hs_t;

    localparam hs_t HS_RST = '{st: HS_IDLE, req: 1'b0, buf_on: 1'b0, rd_p: 1'b0,
                               wr_p: 1'b0, is_wr: 1'b0, addr: '0};

    hs_t hs_d, hs_q;
    logic cyc;

    assign cyc = cyc_rd || cyc_wr;

    always_comb begin
        hs_d      = hs_q;
        hs_d.rd_p = 1'b0;
        hs_d.wr_p = 1'b0;
        commit    = 1'b0;
        case (hs_q.st)
            HS_IDLE: begin
                if (cyc && hit) begin
                    hs_d.st    = HS_REQ;
                    hs_d.req   = 1'b1;
                    hs_d.addr  = addr;
                    hs_d.is_wr = cyc_wr;
                end
            end
            HS_REQ: begin
                if (cyc && arb_gnt) begin
                    hs_d.st     = HS_ACT;
                    hs_d.buf_on = 1'b1;
                    hs_d.rd_p   = !hs_q.is_wr;
                    hs_d.wr_p   = hs_q.is_wr;
                    commit      = hs_q.is_wr;
                end else if (!cyc) begin
                    hs_d.st  = HS_IDLE;
                    hs_d.req = 1'b0;
                end
            end
            HS_ACT: begin
                if (!cyc) begin
                    hs_d.st     = HS_IDLE;
                    hs_d.req    = 1'b0;
                    hs_d.buf_on = 1'b0;
                end
            end
            default: hs_d = HS_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) hs_q <= HS_RST;
        else     hs_q <= hs_d;
    end

    assign arb_req = hs_q.req;
    assign buf_en  = hs_q.buf_on;
    assign rd_en   = hs_q.rd_p;
    assign wr_en   = hs_q.wr_p;
    assign addr_q  = hs_q.addr;
endmodule

// File: rtl/mal_marker.sv
module mal_marker #(
    parameter int POS_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [POS_W-1:0] val,
    output logic [POS_W-1:0] pos
);
    logic [POS_W-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (ld) pos_d = val;
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= pos_d;
    end

    assign pos = pos_q;
endmodule

// File: rtl/marker_addr_latch.sv
module marker_addr_latch #(
    parameter int ADDR_W = mal_pkg::ADDR_W_DEF,
    parameter int POS_W  = mal_pkg::POS_W_DEF,
    parameter logic [ADDR_W-POS_W-1:0] CTL_PAGE = 11'h07D,
    parameter logic [ADDR_W-POS_W-1:0] MK_PAGE0 = 11'h07E
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [ADDR_W-1:0]                      bus_addr,
    input  logic                                   bus_rd,
    input  logic                                   bus_wr,
    input  logic                                   arb_gnt,
    output logic                                   arb_req,
    output logic                                   buf_en,
    output logic                                   rd_en,
    output logic                                   wr_en,
    output logic                                   ctl_sel,
    output logic [mal_pkg::NUM_MK-1:0]             mk_stb,
    output logic [mal_pkg::NUM_MK-1:0][POS_W-1:0]  mk_pos
);
    import mal_pkg::*;

    localparam int PAGE_W = ADDR_W - POS_W;

    logic              live_hit;
    logic [ADDR_W-1:0] held_addr;
    logic              commit;
    logic              held_ctl;
    logic              held_any;
    logic [NUM_MK-1:0] held_mk;

    // live decode drives the window selects
    mal_decode #(.PAGE_W(PAGE_W), .CTL_PAGE(CTL_PAGE), .MK_PAGE0(MK_PAGE0)) u_dec_live (
        .cyc     (bus_rd || bus_wr),
        .page    (bus_addr[ADDR_W-1:POS_W]),
        .ctl_hit (ctl_sel),
        .mk_hit  (mk_stb),
        .any_hit (live_hit)
    );

    // decode of the address captured at request time steers the marker load
    mal_decode #(.PAGE_W(PAGE_W), .CTL_PAGE(CTL_PAGE), .MK_PAGE0(MK_PAGE0)) u_dec_held (
        .cyc     (1'b1),
        .page    (held_addr[ADDR_W-1:POS_W]),
        .ctl_hit (held_ctl),
        .mk_hit  (held_mk),
        .any_hit (held_any)
    );

    mal_handshake #(.ADDR_W(ADDR_W)) u_hs (
        .clk     (clk),
        .rst     (rst),
        .cyc_rd  (bus_rd),
        .cyc_wr  (bus_wr),
        .hit     (live_hit),
        .addr    (bus_addr),
        .arb_gnt (arb_gnt),
        .arb_req (arb_req),
        .buf_en  (buf_en),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr_q  (held_addr),
        .commit  (commit)
    );

    for (genvar k = 0; k < NUM_MK; k++) begin : g_mk
        mal_marker #(.POS_W(POS_W)) u_mk (
            .clk (clk),
            .rst (rst),
            .ld  (commit && held_mk[k] && held_any && !held_ctl),
            .val (held_addr[POS_W-1:0]),
            .pos (mk_pos[k])
        );
    end
endmodule

// File: rtl/mal_checker.sv
module mal_checker #(
    parameter int POS_W = 9
) (
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  bus_rd,
    input logic                                  bus_wr,
    input logic                                  arb_gnt,
    input logic                                  arb_req,
    input logic                                  buf_en,
    input logic                                  rd_en,
    input logic                                  wr_en,
    input logic                                  ctl_sel,
    input logic [mal_pkg::NUM_MK-1:0]            mk_stb,
    input logic [mal_pkg::NUM_MK-1:0][POS_W-1:0] mk_pos
);
    // R1 R2: the windows are disjoint
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl_sel, mk_stb}));

    // R3: no window hit and no pending request means no request next cycle
    a_r3_no_stray_req: assert property (@(posedge clk) disable iff (rst)
        (!ctl_sel && mk_stb == '0 && !arb_req) |=> !arb_req);

    // R4: the request holds while the bus cycle continues
    a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
        (arb_req && (bus_rd || bus_wr)) |=> arb_req);

    // R5: the buffer enable rises only after a grant to a pending request
    a_r5_buf_after_gnt: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_en) |-> ($past(arb_gnt) && $past(arb_req)));

    // R5: no buffer enable without a request
    a_r5_buf_needs_req: assert property (@(posedge clk) disable iff (rst)
        buf_en |-> arb_req);

    // R6: the read and write strobes are single-cycle pulses inside the buffer enable
    a_r6_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
    a_r6_rd_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);
    a_r6_strobe_in_buf: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) |-> (buf_en && !(rd_en && wr_en)));

    // R8: a marker moves only together with a write strobe
    a_r8_move_on_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(mk_pos) |-> wr_en);

    // R9: reset clears the outputs
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!arb_req && !buf_en && !rd_en && !wr_en && mk_pos == '0));
endmodule

bind marker_addr_latch mal_checker #(.POS_W(POS_W)) u_chk (.*);

// File: tb/marker_addr_latch_tb.sv
module marker_addr_latch_tb;
    logic              clk = 1'b0;
    logic              rst;
    logic [19:0]       bus_addr;
    logic              bus_rd;
    logic              bus_wr;
    logic              arb_gnt;
    logic              arb_req;
    logic              buf_en;
    logic              rd_en;
    logic              wr_en;
    logic              ctl_sel;
    logic [1:0]        mk_stb;
    logic [1:0][8:0]   mk_pos;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    marker_addr_latch u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .arb_gnt(arb_gnt), .arb_req(arb_req), .buf_en(buf_en), .rd_en(rd_en),
        .wr_en(wr_en), .ctl_sel(ctl_sel), .mk_stb(mk_stb), .mk_pos(mk_pos)
    );

    typedef struct packed {
        logic [19:0] addr;
        logic        wr;
        logic        ectl;
        logic        em1;
        logic        em2;
        logic        ehit;
        logic [8:0]  p1;
        logic [8:0]  p2;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{20'h0FCE3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 9'h0E3, 9'h000},
        '{20'h0FFF9, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0E3, 9'h1F9},
        '{20'h0FA10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 9'h0E3, 9'h1F9},
        '{20'h0FD00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'h0E3, 9'h1F9},
        '{20'h0FC00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 9'h000, 9'h1F9},
        '{20'h0FDFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 9'h1FF, 9'h1F9},
        '{20'h0FE00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'h1FF, 9'h000},
        '{20'h1FC40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1FF, 9'h000},
        '{20'h0F9FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1FF, 9'h000},
        '{20'h0FBFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 9'h1FF, 9'h000},
        '{20'h0FEAB, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'h1FF, 9'h000}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_pos(input string tag, input logic [8:0] e1, input logic [8:0] e2);
        check(mk_pos == {e2, e1}, tag, {14'd0, mk_pos}, {14'd0, e2, e1});
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        bus_addr = v.addr;
        bus_wr   = v.wr;
        bus_rd   = !v.wr;
        #1;
        check({ctl_sel, mk_stb[1], mk_stb[0]} == {v.ectl, v.em2, v.em1},
              "R1 R2 window select", {29'd0, ctl_sel, mk_stb[1], mk_stb[0]},
              {29'd0, v.ectl, v.em2, v.em1});
        @(negedge clk);
        check(arb_req == v.ehit, v.ehit ? "R4 request raised" : "R3 no request outside",
              {31'd0, arb_req}, {31'd0, v.ehit});
        if (v.ehit) begin
            check(!buf_en, "R5 no buffer before grant", {31'd0, buf_en}, 32'd0);
            arb_gnt = 1'b1;
            @(negedge clk);
            check(buf_en && (v.wr ? (wr_en && !rd_en) : (rd_en && !wr_en)),
                  "R6 strobe with buffer", {29'd0, buf_en, rd_en, wr_en},
                  {29'd0, 1'b1, !v.wr, v.wr});
            check_pos((v.wr && (v.em1 || v.em2)) ? "R7 position from address"
                                                 : "R8 position unchanged", v.p1, v.p2);
            arb_gnt = 1'b0;
            bus_rd  = 1'b0;
            bus_wr  = 1'b0;
            @(negedge clk);
            check(!arb_req && !buf_en, "R4 release after cycle end",
                  {30'd0, arb_req, buf_en}, 32'd0);
        end else begin
            bus_rd = 1'b0;
            bus_wr = 1'b0;
            @(negedge clk);
            check_pos("R3 position unchanged", v.p1, v.p2);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        bus_addr = '0;
        bus_rd   = 1'b0;
        bus_wr   = 1'b0;
        arb_gnt  = 1'b0;
        repeat (3) @(negedge clk);
        check(!arb_req && !buf_en && !rd_en && !wr_en, "R9 reset outputs",
              {28'd0, arb_req, buf_en, rd_en, wr_en}, 32'd0);
        check_pos("R9 reset positions", 9'h000, 9'h000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(TBL[i]);

        // R10: stray grant with no pending request
        @(negedge clk);
        arb_gnt = 1'b1;
        repeat (3) @(negedge clk);
        check(!arb_req && !buf_en && !wr_en && !rd_en, "R10 stray grant ignored",
              {28'd0, arb_req, buf_en, rd_en, wr_en}, 32'd0);
        arb_gnt = 1'b0;

        // R5: delayed grant; R4/R6: long bus cycle
        @(negedge clk);
        bus_addr = 20'h0FC55;
        bus_wr   = 1'b1;
        repeat (4) @(negedge clk);
        check(arb_req && !buf_en, "R5 waiting for grant",
              {30'd0, arb_req, buf_en}, {30'd0, 2'b10});
        check_pos("R8 no update before grant", 9'h1FF, 9'h000);
        arb_gnt = 1'b1;
        @(negedge clk);
        check_pos("R7 delayed grant position", 9'h055, 9'h000);
        arb_gnt = 1'b0;
        repeat (2) @(negedge clk);
        check(arb_req && buf_en && !wr_en, "R6 R4 held cycle, single strobe",
              {29'd0, arb_req, buf_en, wr_en}, {29'd0, 3'b110});
        bus_wr = 1'b0;
        @(negedge clk);
        check(!arb_req && !buf_en, "R4 release after long cycle",
              {30'd0, arb_req, buf_en}, 32'd0);

        // R8: request aborted before grant
        bus_addr = 20'h0FE77;
        bus_wr   = 1'b1;
        @(negedge clk);
        check(arb_req, "R4 request for abort case", {31'd0, arb_req}, 32'd1);
        bus_wr = 1'b0;
        @(negedge clk);
        check(!arb_req, "R4 request dropped on abort", {31'd0, arb_req}, 32'd0);
        arb_gnt = 1'b1;
        @(negedge clk);
        check(!buf_en && !wr_en, "R10 late grant after abort",
              {30'd0, buf_en, wr_en}, 32'd0);
        check_pos("R8 aborted write no update", 9'h055, 9'h000);
        arb_gnt = 1'b0;

        // R9: reset clears latched positions
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_pos("R9 reset clears positions", 9'h000, 9'h000);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule